// File: doc/BRIEF.md
# Three-Lane Bit-Reversed PWM DAC

This block drives three independent single-bit pulse-width-modulated lines, each set by an 8-bit duty value. A host writes a duty value by presenting it together with a one-cycle load strobe. The block then keeps that lane's value as a bit-reversed working image. An external RC filter turns each line into an analog level proportional to duty/256.

One shared 8-bit phase counter advances on every cycle in which `tick_en` is high and wraps from 255 to 0. That wrap marks a 256-tick period. On each tick a lane is high when the bit-reversed phase is below the lane's duty. The number of high ticks in a period therefore equals the duty, and those ticks are scattered across the period instead of forming one block. This keeps the ripple after the filter small.

A new value reaches the lane's working image at once. The compare logic only adopts it at the next period boundary, so no period ever mixes two duties.

Top module: `bitrev_pwm_dac`

## Requirements
- R1: After reset every output is low, and it stays low for a full period while nothing has been loaded.
- R2: The phase counter advances by one per cycle with `tick_en` high and wraps from 255 to 0, so a period is 256 ticks. While `tick_en` is low, the counter and every output hold their values.
- R3: A lane whose active duty is 0 is low on every tick.
- R4: A lane whose active duty is 255 is high on every tick except the one where the phase counter is 255.
- R5: Over every full period, a lane is high on exactly as many ticks as its active duty value (0 to 255).
- R6: On a tick with phase counter value p, a lane is high exactly when the 8-bit reversal of p (bit i moved to bit 7-i) is numerically less than the active duty. With duty 128, for example, the lane is high on every even phase value.
- R7: A value loaded partway through a period does not change that lane's output before the counter wraps. The new value is in effect from phase 0 of the next period.
- R8: A value loaded on the same edge on which the counter wraps is in effect from phase 0 of the period that starts at that edge.
- R9: Loading one lane leaves the other lanes' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the phase counter by one tick |
| duty0 | input | 8 | Duty value for lane 0 |
| load0 | input | 1 | Load strobe for lane 0 |
| duty1 | input | 8 | Duty value for lane 1 |
| load1 | input | 1 | Load strobe for lane 1 |
| duty2 | input | 8 | Duty value for lane 2 |
| load2 | input | 1 | Load strobe for lane 2 |
| pwm0 | output | 1 | PWM line for lane 0 |
| pwm1 | output | 1 | PWM line for lane 1 |
| pwm2 | output | 1 | PWM line for lane 2 |

## Verification
The two functions that can fall on the same edge are a load strobe and the period wrap. The lane must then take the incoming value straight into its active compare instead of the image it held before that edge. The bench provokes this by raising all three strobes on the cycle where its own phase model reads 255 with `tick_en` high. It then judges the period that follows tick by tick, and by its high count, against the new values. A separate scenario loads at phase 100 and confirms that the rest of that period still follows the old values.

// File: rtl/bitrev_pwm_pkg.sv
package bitrev_pwm_pkg;
  localparam int unsigned PWM_DUTY_W = 8;
  localparam int unsigned PWM_LANES  = 3;
  typedef logic [PWM_DUTY_W-1:0] duty_t;
endpackage

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] phase,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = '1;

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (tick_en) phase_q <= phase_q + 1'b1;
  end

  assign phase = phase_q;
  assign wrap  = tick_en && (phase_q == LAST);

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && phase_q == LAST) |=> (phase_q == '0));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(phase_q));
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic [W-1:0] phase,
  output logic         pwm
);
  localparam logic [W-1:0] ALL1 = '1;

  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [W-1:0] image_q;   // working image, updated on load
  logic [W-1:0] active_q;  // image the compare uses this period

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      image_q  <= '0;
      active_q <= '0;
    end else begin
      if (load) image_q <= mirror(din);
      if (wrap) active_q <= load ? mirror(din) : image_q;
    end
  end

  assign pwm = mirror(phase) < mirror(active_q);

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_q));
  // R8
  wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && load) |=> (active_q == image_q));
  // R3
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> !pwm);
  // R4
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == ALL1) |-> (pwm == (phase != ALL1)));
endmodule

// File: rtl/bitrev_pwm_dac.sv
module bitrev_pwm_dac
  import bitrev_pwm_pkg::*;
#(
  parameter int unsigned DUTY_W = PWM_DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [DUTY_W-1:0] duty0,
  input  logic              load0,
  input  logic [DUTY_W-1:0] duty1,
  input  logic              load1,
  input  logic [DUTY_W-1:0] duty2,
  input  logic              load2,
  output logic              pwm0,
  output logic              pwm1,
  output logic              pwm2
);
  localparam int unsigned NL = PWM_LANES;

  logic [DUTY_W-1:0] phase;
  logic              wrap;
  logic [DUTY_W-1:0] din  [NL];
  logic [NL-1:0]     ld;
  logic [NL-1:0]     outs;

  assign din[0] = duty0;
  assign din[1] = duty1;
  assign din[2] = duty2;
  assign ld     = {load2, load1, load0};

  pwm_phase_counter #(.W(DUTY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .phase(phase), .wrap(wrap)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    pwm_lane #(.W(DUTY_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .load(ld[g]),
      .din(din[g]), .phase(phase), .pwm(outs[g])
    );
  end

  assign pwm0 = outs[0];
  assign pwm1 = outs[1];
  assign pwm2 = outs[2];

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (outs == '0));
endmodule

// File: tb/bitrev_pwm_dac_test.sv
module bitrev_pwm_dac_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [7:0] d [3];
  logic [2:0] ld = '0;
  logic pwm0, pwm1, pwm2;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bitrev_pwm_dac uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .duty0(d[0]), .load0(ld[0]), .duty1(d[1]), .load1(ld[1]),
    .duty2(d[2]), .load2(ld[2]),
    .pwm0(pwm0), .pwm1(pwm1), .pwm2(pwm2)
  );

  // bench-side phase and duty model
  logic [7:0] mcnt = '0;
  logic [7:0] pend [3];
  logic [7:0] act  [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0;
      for (int k = 0; k < 3; k++) begin pend[k] <= '0; act[k] <= '0; end
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (ld[k]) pend[k] <= d[k];
        if (tick_en && mcnt == 8'd255) act[k] <= ld[k] ? d[k] : pend[k];
      end
      if (tick_en) mcnt <= mcnt + 8'd1;
    end
  end

  function automatic logic [7:0] flip(input logic [7:0] x);
    return {<<{x}};
  endfunction

  function automatic logic pin(input int k);
    return (k == 0) ? pwm0 : (k == 1) ? pwm1 : pwm2;
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic load_lanes(input logic [2:0] which, input logic [7:0] a,
                            input logic [7:0] b, input logic [7:0] c);
    d[0] = a; d[1] = b; d[2] = c; ld = which;
    @(negedge clk);
    ld = '0;
  endtask

  // samples one whole period from phase 0; checks counts and each tick
  task automatic run_period(input string req, input int e0, input int e1, input int e2);
    int hi [3];
    int bad = 0;
    int expv [3];
    expv[0] = e0; expv[1] = e1; expv[2] = e2;
    for (int k = 0; k < 3; k++) hi[k] = 0;
    while (mcnt != 8'd0) @(negedge clk);
    for (int t = 0; t < 256; t++) begin
      for (int k = 0; k < 3; k++) begin
        if (pin(k)) hi[k]++;
        if (pin(k) != (flip(mcnt) < 8'(expv[k]))) bad++;
      end
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) check({req, " R5 high count"}, hi[k], expv[k]);
    check({req, " R6 per-tick pattern mismatches"}, bad, 0);
  endtask

  task automatic t_reset();
    check("R1 outputs after reset", {pwm2, pwm1, pwm0}, 0);
    tick_en = 1'b1;
    run_period("R1 idle period", 0, 0, 0);
  endtask

  task automatic t_values(input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input string req);
    load_lanes(3'b111, a, b, c);
    while (mcnt != 8'd0) @(negedge clk);
    @(negedge clk);
    run_period(req, a, b, c);
  endtask

  task automatic t_full_low_tick();
    int low_at = -1;
    int lows = 0;
    load_lanes(3'b111, 8'd255, 8'd0, 8'd128);
    while (mcnt != 8'd0) @(negedge clk);
    @(negedge clk);
    while (mcnt != 8'd0) @(negedge clk);
    for (int t = 0; t < 256; t++) begin
      if (!pwm0) begin lows++; low_at = mcnt; end
      if (pwm1) check("R3 zero duty tick high", 1, 0);
      if (pwm2 != !mcnt[0]) check("R6 duty 128 even-phase pattern", pwm2, !mcnt[0]);
      @(negedge clk);
    end
    check("R4 duty 255 low ticks", lows, 1);
    check("R4 duty 255 low phase", low_at, 255);
  endtask

  task automatic t_midload();
    int bad = 0;
    load_lanes(3'b111, 8'd10, 8'd200, 8'd77);
    while (mcnt != 8'd0) @(negedge clk);
    while (mcnt != 8'd100) @(negedge clk);
    d[0] = 8'd240; d[1] = 8'd3; d[2] = 8'd150; ld = 3'b111;
    for (int t = 100; t < 256; t++) begin
      if (pwm0 != (flip(mcnt) < 8'd10))  bad++;
      if (pwm1 != (flip(mcnt) < 8'd200)) bad++;
      if (pwm2 != (flip(mcnt) < 8'd77))  bad++;
      @(negedge clk);
      ld = '0;
    end
    check("R7 old duty kept until wrap", bad, 0);
    run_period("R7 new duty after wrap", 240, 3, 150);
  endtask

  task automatic t_wrapload();
    load_lanes(3'b111, 8'd5, 8'd5, 8'd5);
    while (mcnt != 8'd0) @(negedge clk);
    @(negedge clk);
    while (mcnt != 8'd255) @(negedge clk);
    load_lanes(3'b111, 8'd99, 8'd1, 8'd254);
    check("R8 phase after wrap edge", mcnt, 0);
    run_period("R8 load on wrap edge", 99, 1, 254);
  endtask

  task automatic t_single_lane();
    load_lanes(3'b111, 8'd60, 8'd70, 8'd80);
    while (mcnt != 8'd0) @(negedge clk);
    @(negedge clk);
    load_lanes(3'b010, 8'd0, 8'd200, 8'd0);
    run_period("R9 only lane 1 changed", 60, 200, 80);
  endtask

  task automatic t_hold();
    logic [2:0] snap;
    logic [7:0] ph;
    int moved = 0;
    load_lanes(3'b111, 8'd128, 8'd37, 8'd201);
    while (mcnt != 8'd0) @(negedge clk);
    while (mcnt != 8'd40) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    snap = {pwm2, pwm1, pwm0};
    ph = mcnt;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if ({pwm2, pwm1, pwm0} != snap) moved++;
    end
    check("R2 outputs frozen with tick_en low", moved, 0);
    check("R2 model phase frozen", mcnt, ph);
    tick_en = 1'b1;
    run_period("R2 period after pause", 128, 37, 201);
  endtask

  initial begin
    d[0] = '0; d[1] = '0; d[2] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_values(8'd0, 8'd1, 8'd128, "R3 zero/one/half");
    t_values(8'd255, 8'd128, 8'd0, "R4 full/half/zero");
    t_values(8'($urandom_range(1, 254)), 8'($urandom_range(1, 254)),
             8'($urandom_range(1, 254)), "R5 random set A");
    t_values(8'($urandom_range(1, 254)), 8'($urandom_range(1, 254)),
             8'($urandom_range(1, 254)), "R5 random set B");
    t_full_low_tick();
    t_midload();
    t_wrapload();
    t_single_lane();
    t_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule